// File: doc/BRIEF.md
# Tile Index and Interpolation Weight Generator

This block sits in the pixel path of a tiled, locally adaptive contrast stage. Each valid pixel comes with its column and row coordinates. From these, plus the image size and the tile size, the block produces three things for each axis:

- the tile whose histogram the pixel contributes to;
- the pair of neighbouring tiles whose mapping functions are blended for this pixel;
- the fixed-point weight of that blend.

The interpolation grid is shifted half a tile against the histogram grid. A pixel therefore usually blends between its own tile and the neighbour on the nearer side. Pixels closer to the image border than half a tile have no neighbour on one side. For such a pixel the block reports a bypass flag for that axis. A pixel that bypasses both axes is also flagged as a corner pixel.

Tile sizes are powers of two, selected at run time as a base-two logarithm for each axis. This reduces every division to a shift and a mask. All outputs come from a single register stage. Results appear one clock after the coordinates are presented. While no pixel is valid, the outputs keep their last values.

Top module: `tile_interp_indexer`

## Requirements
Notation used below. For an axis, c is the coordinate and N is the image size. k is the clamped tile log2 and T = 2^k is the tile size. The last tile index L equals min(max(floor(N/T), 1), 2^TIDX_W) - 1. The defaults are TIDX_W=6, FRAC_W=8, KMIN=2 and KMAX=6.

- R1: The histogram index for an axis is min(floor(c/T), L).
- R2: For an interior pixel, the low blend index is floor((c - T/2)/T) and the high blend index is the low index plus one. A pixel is interior when c >= T/2 and floor((c - T/2)/T) < L.
- R3: For an interior pixel, the blend weight equals ((c - T/2) mod T) multiplied by 2^(FRAC_W-k), as an unsigned FRAC_W-bit value.
- R4: For a pixel with c < T/2, both blend indices are 0, the weight is 0 and the bypass flag of that axis is 1.
- R5: For a pixel with c >= T/2 and floor((c - T/2)/T) >= L, both blend indices are L, the weight is 0 and the bypass flag is 1.
- R6: The row axis follows R1 to R5 using the row coordinate, the image height and the tile-height log2. The column axis uses the column coordinate, the image width and the tile-width log2.
- R7: The corner flag is 1 exactly when both bypass flags are 1.
- R8: out_valid equals in_valid from one clock earlier. All index, weight and flag outputs reflect the inputs sampled at that same earlier edge.
- R9: A cycle with in_valid low leaves every index, weight and flag output unchanged, whatever the coordinates and sizes are.
- R10: While rst_n is low, every output is 0.
- R11: A tile log2 input below KMIN is treated as KMIN. One above KMAX is treated as KMAX.
- R12: The tile count of an axis saturates at 2^TIDX_W. An image size smaller than one tile counts as one tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Coordinates are valid this cycle |
| pix_x | input | COORD_W | Pixel column |
| pix_y | input | COORD_W | Pixel row |
| img_w | input | COORD_W | Image width in pixels |
| img_h | input | COORD_W | Image height in pixels |
| tile_w_log2 | input | K_W | Log2 of tile width |
| tile_h_log2 | input | K_W | Log2 of tile height |
| out_valid | output | 1 | Registered in_valid |
| hist_col | output | TIDX_W | Histogram tile column |
| hist_row | output | TIDX_W | Histogram tile row |
| left_col | output | TIDX_W | Low blend column |
| right_col | output | TIDX_W | High blend column |
| top_row | output | TIDX_W | Low blend row |
| bottom_row | output | TIDX_W | High blend row |
| frac_x | output | FRAC_W | Horizontal blend weight |
| frac_y | output | FRAC_W | Vertical blend weight |
| bypass_x | output | 1 | Skip horizontal blend |
| bypass_y | output | 1 | Skip vertical blend |
| corner | output | 1 | Skip both blends |

## Verification
A pixel may be in a margin on one axis while the other axis takes the normal blended path. The same pixel may also satisfy both margin conditions together, which is the corner case. Random coordinates over random image and tile sizes produce all of these mixes. Directed pixels pin the exact boundary values: T/2-1, T/2, and the first coordinate of the high margin. A bench model derives each axis from integer division and remainder. The corner flag is judged against the two bypass flags the model expects for that same pixel.

// File: rtl/tidx_pkg.sv
package tidx_pkg;
   typedef enum logic {AX_COL = 1'b0, AX_ROW = 1'b1} tidx_axis_e;
   localparam int NUM_AXES = 2;

   function automatic int unsigned clamp_int(int unsigned v, int unsigned lo, int unsigned hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction
endpackage

// File: rtl/tidx_klimit.sv
module tidx_klimit #(
   parameter int K_W  = 3,
   parameter int KMIN = 2,
   parameter int KMAX = 6
) (
   input  logic [K_W-1:0] k_in,
   output logic [K_W-1:0] k_out
);
   localparam logic [K_W-1:0] KLO = K_W'(KMIN);
   localparam logic [K_W-1:0] KHI = K_W'(KMAX);

   generate
      if (KMIN == KMAX) begin : g_fixed
         assign k_out = KLO;
      end else begin : g_range
         always_comb begin
            if (k_in < KLO)      k_out = KLO;
            else if (k_in > KHI) k_out = KHI;
            else                 k_out = k_in;
         end
      end
   endgenerate
endmodule

// File: rtl/tidx_frac_scale.sv
module tidx_frac_scale #(
   parameter int K_W    = 3,
   parameter int KMIN   = 2,
   parameter int KMAX   = 6,
   parameter int FRAC_W = 8
) (
   input  logic [FRAC_W-1:0] rem,
   input  logic [K_W-1:0]    k,
   output logic [FRAC_W-1:0] frac
);
   localparam int SH_W = $clog2(FRAC_W + 1);

   generate
      if (KMIN == KMAX) begin : g_const
         assign frac = rem << (FRAC_W - KMAX);
      end else begin : g_var
         logic [SH_W-1:0] sh;
         assign sh   = SH_W'(FRAC_W) - SH_W'(k);
         assign frac = rem << sh;
      end
   endgenerate
endmodule

// File: rtl/tidx_axis.sv
module tidx_axis #(
   parameter int COORD_W = 12,
   parameter int TIDX_W  = 6,
   parameter int FRAC_W  = 8,
   parameter int K_W     = 3,
   parameter int KMIN    = 2,
   parameter int KMAX    = 6
) (
   input  logic [COORD_W-1:0] c,
   input  logic [COORD_W-1:0] n,
   input  logic [K_W-1:0]     k_raw,
   output logic [TIDX_W-1:0]  hist,
   output logic [TIDX_W-1:0]  lo,
   output logic [TIDX_W-1:0]  hi,
   output logic [FRAC_W-1:0]  frac,
   output logic               byp
);
   localparam logic [COORD_W-1:0] MAX_LAST = COORD_W'((1 << TIDX_W) - 1);

   logic [K_W-1:0]     k;
   logic [COORD_W-1:0] tsize, half, tmask, nt_raw, last_c, hraw, d, qraw, rem;
   logic               low, high;
   logic [FRAC_W-1:0]  frac_sc;

   tidx_klimit #(.K_W(K_W), .KMIN(KMIN), .KMAX(KMAX)) u_klim (
      .k_in (k_raw),
      .k_out(k)
   );

   always_comb begin
      tsize  = COORD_W'(1) << k;
      half   = tsize >> 1;
      tmask  = tsize - COORD_W'(1);
      nt_raw = n >> k;
      if (nt_raw == '0)           last_c = '0;
      else if (nt_raw > MAX_LAST) last_c = MAX_LAST;
      else                        last_c = nt_raw - COORD_W'(1);
      hraw = c >> k;
      low  = (c < half);
      d    = c - half;
      qraw = d >> k;
      high = !low && (qraw >= last_c);
      rem  = d & tmask;
   end

   tidx_frac_scale #(.K_W(K_W), .KMIN(KMIN), .KMAX(KMAX), .FRAC_W(FRAC_W)) u_scale (
      .rem (FRAC_W'(rem)),
      .k   (k),
      .frac(frac_sc)
   );

   always_comb begin
      hist = (hraw > last_c) ? TIDX_W'(last_c) : TIDX_W'(hraw);
      byp  = low | high;
      if (low) begin
         lo   = '0;
         hi   = '0;
         frac = '0;
      end else if (high) begin
         lo   = TIDX_W'(last_c);
         hi   = TIDX_W'(last_c);
         frac = '0;
      end else begin
         lo   = TIDX_W'(qraw);
         hi   = TIDX_W'(qraw) + TIDX_W'(1);
         frac = frac_sc;
      end
   end
endmodule

// File: rtl/tile_interp_indexer.sv
module tile_interp_indexer
   import tidx_pkg::*;
#(
   parameter int COORD_W = 12,
   parameter int TIDX_W  = 6,
   parameter int FRAC_W  = 8,
   parameter int KMIN    = 2,
   parameter int KMAX    = 6,
   parameter int K_W     = $clog2(KMAX + 2)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [COORD_W-1:0] pix_x,
   input  logic [COORD_W-1:0] pix_y,
   input  logic [COORD_W-1:0] img_w,
   input  logic [COORD_W-1:0] img_h,
   input  logic [K_W-1:0]     tile_w_log2,
   input  logic [K_W-1:0]     tile_h_log2,
   output logic               out_valid,
   output logic [TIDX_W-1:0]  hist_col,
   output logic [TIDX_W-1:0]  hist_row,
   output logic [TIDX_W-1:0]  left_col,
   output logic [TIDX_W-1:0]  right_col,
   output logic [TIDX_W-1:0]  top_row,
   output logic [TIDX_W-1:0]  bottom_row,
   output logic [FRAC_W-1:0]  frac_x,
   output logic [FRAC_W-1:0]  frac_y,
   output logic               bypass_x,
   output logic               bypass_y,
   output logic               corner
);
   generate
      if (KMIN < 1)              begin : g_e1 $error("KMIN must be at least 1"); end
      if (KMAX < KMIN)           begin : g_e2 $error("KMAX below KMIN"); end
      if (FRAC_W < KMAX)         begin : g_e3 $error("FRAC_W must cover the largest tile"); end
      if (KMAX >= COORD_W)       begin : g_e4 $error("tile wider than coordinate range"); end
      if (TIDX_W >= COORD_W)     begin : g_e5 $error("TIDX_W must be below COORD_W"); end
      if ((1 << K_W) <= KMAX)    begin : g_e6 $error("K_W too narrow for KMAX"); end
   endgenerate

   logic [COORD_W-1:0] crd   [NUM_AXES];
   logic [COORD_W-1:0] dim   [NUM_AXES];
   logic [K_W-1:0]     klog  [NUM_AXES];
   logic [TIDX_W-1:0]  c_hist[NUM_AXES], c_lo[NUM_AXES], c_hi[NUM_AXES];
   logic [FRAC_W-1:0]  c_frac[NUM_AXES];
   logic               c_byp [NUM_AXES];
   logic [TIDX_W-1:0]  r_hist[NUM_AXES], r_lo[NUM_AXES], r_hi[NUM_AXES];
   logic [FRAC_W-1:0]  r_frac[NUM_AXES];
   logic               r_byp [NUM_AXES];
   logic               r_corner, r_valid;

   assign crd[AX_COL]  = pix_x;
   assign crd[AX_ROW]  = pix_y;
   assign dim[AX_COL]  = img_w;
   assign dim[AX_ROW]  = img_h;
   assign klog[AX_COL] = tile_w_log2;
   assign klog[AX_ROW] = tile_h_log2;

   for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
      tidx_axis #(
         .COORD_W(COORD_W), .TIDX_W(TIDX_W), .FRAC_W(FRAC_W),
         .K_W(K_W), .KMIN(KMIN), .KMAX(KMAX)
      ) u_axis (
         .c    (crd[a]),
         .n    (dim[a]),
         .k_raw(klog[a]),
         .hist (c_hist[a]),
         .lo   (c_lo[a]),
         .hi   (c_hi[a]),
         .frac (c_frac[a]),
         .byp  (c_byp[a])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_hist[a] <= '0;
            r_lo[a]   <= '0;
            r_hi[a]   <= '0;
            r_frac[a] <= '0;
            r_byp[a]  <= 1'b0;
         end else if (in_valid) begin
            r_hist[a] <= c_hist[a];
            r_lo[a]   <= c_lo[a];
            r_hi[a]   <= c_hi[a];
            r_frac[a] <= c_frac[a];
            r_byp[a]  <= c_byp[a];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_valid  <= 1'b0;
         r_corner <= 1'b0;
      end else begin
         r_valid <= in_valid;
         if (in_valid) r_corner <= c_byp[AX_COL] & c_byp[AX_ROW];
      end
   end

   assign out_valid  = r_valid;
   assign hist_col   = r_hist[AX_COL];
   assign hist_row   = r_hist[AX_ROW];
   assign left_col   = r_lo[AX_COL];
   assign right_col  = r_hi[AX_COL];
   assign top_row    = r_lo[AX_ROW];
   assign bottom_row = r_hi[AX_ROW];
   assign frac_x     = r_frac[AX_COL];
   assign frac_y     = r_frac[AX_ROW];
   assign bypass_x   = r_byp[AX_COL];
   assign bypass_y   = r_byp[AX_ROW];
   assign corner     = r_corner;

   // R2: interior pixels blend two adjacent tiles
   a_r2_adjacent_pair: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !bypass_x |-> right_col == left_col + TIDX_W'(1));
   // R1/R2: the histogram tile of an interior pixel is one of its blend pair
   a_r1_hist_in_pair: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !bypass_y |-> (hist_row == top_row) || (hist_row == bottom_row));
   // R4/R5: margins carry zero weight and a collapsed pair
   a_r5_margin_collapsed: assert property (@(posedge clk) disable iff (!rst_n)
      bypass_x |-> frac_x == '0 && left_col == right_col);
   // R7: corner implies both bypasses
   a_r7_corner_both: assert property (@(posedge clk) disable iff (!rst_n)
      corner |-> bypass_x && bypass_y);
   // R8: one-cycle valid latency
   a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r8_idle_latency: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R9: idle cycles hold the results
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(hist_col) && $stable(left_col) && $stable(frac_x)
                 && $stable(hist_row) && $stable(top_row) && $stable(frac_y)
                 && $stable(corner));
endmodule

// File: tb/tb_tile_interp_indexer.sv
module tb_tile_interp_indexer;
   localparam int COORD_W = 12, TIDX_W = 6, FRAC_W = 8, KMIN = 2, KMAX = 6, K_W = 3;

   logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
   logic [COORD_W-1:0] pix_x = '0, pix_y = '0, img_w = '0, img_h = '0;
   logic [K_W-1:0] tile_w_log2 = '0, tile_h_log2 = '0;
   logic out_valid, bypass_x, bypass_y, corner;
   logic [TIDX_W-1:0] hist_col, hist_row, left_col, right_col, top_row, bottom_row;
   logic [FRAC_W-1:0] frac_x, frac_y;

   int n_tests = 0, n_fail = 0;

   tile_interp_indexer #(.COORD_W(COORD_W), .TIDX_W(TIDX_W), .FRAC_W(FRAC_W),
                         .KMIN(KMIN), .KMAX(KMAX), .K_W(K_W)) dut (.*);

   always #5 clk = ~clk;

   initial begin
      #2000000;
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish (actual hung, expected done)");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   typedef struct { int h, lo, hi, f, b; } ax_t;

   function automatic ax_t model(int c, int n, int kin);
      ax_t r;
      int k = (kin < KMIN) ? KMIN : ((kin > KMAX) ? KMAX : kin);
      int t = 1 << k, half = t / 2, nt = n / t, last, q;
      if (nt < 1) nt = 1;
      if (nt > (1 << TIDX_W)) nt = 1 << TIDX_W;
      last = nt - 1;
      r.h = (c / t > last) ? last : c / t;
      if (c < half) begin
         r.lo = 0; r.hi = 0; r.f = 0; r.b = 1;
      end else begin
         q = (c - half) / t;
         if (q >= last) begin
            r.lo = last; r.hi = last; r.f = 0; r.b = 1;
         end else begin
            r.lo = q; r.hi = q + 1; r.f = ((c - half) % t) * (1 << (FRAC_W - k)); r.b = 0;
         end
      end
      return r;
   endfunction

   task automatic chk(string tag, string what, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic drive(bit v, int x, int y, int w, int h, int kw, int kh);
      @(negedge clk);
      in_valid = v; pix_x = COORD_W'(x); pix_y = COORD_W'(y);
      img_w = COORD_W'(w); img_h = COORD_W'(h);
      tile_w_log2 = K_W'(kw); tile_h_log2 = K_W'(kh);
      @(negedge clk);
   endtask

   task automatic check_all(string ctag, ax_t ex, ax_t ey);
      string tx = ex.b ? ((ex.lo == 0 && ex.hi == 0 && ex.h == 0) ? "R4" : (ex.lo == 0 ? "R4" : "R5")) : "R2";
      chk(ctag == "" ? "R1" : ctag, "hist_col", hist_col, ex.h);
      chk(ctag == "" ? tx : ctag, "left_col", left_col, ex.lo);
      chk(ctag == "" ? tx : ctag, "right_col", right_col, ex.hi);
      chk(ctag == "" ? "R3" : ctag, "frac_x", frac_x, ex.f);
      chk(ctag == "" ? tx : ctag, "bypass_x", bypass_x, ex.b);
      chk("R6", "hist_row", hist_row, ey.h);
      chk("R6", "top_row", top_row, ey.lo);
      chk("R6", "bottom_row", bottom_row, ey.hi);
      chk("R6", "frac_y", frac_y, ey.f);
      chk("R6", "bypass_y", bypass_y, ey.b);
      chk("R7", "corner", corner, ex.b & ey.b);
   endtask

   task automatic run_pix(string ctag, int x, int y, int w, int h, int kw, int kh);
      drive(1'b1, x, y, w, h, kw, kh);
      chk("R8", "out_valid", out_valid, 1);
      check_all(ctag, model(x, w, kw), model(y, h, kh));
   endtask

   initial begin
      void'($urandom(32'h5eed_0042));
      repeat (3) @(negedge clk);
      chk("R10", "out_valid", out_valid, 0);
      chk("R10", "hist_col", hist_col, 0);
      chk("R10", "right_col", right_col, 0);
      chk("R10", "frac_y", frac_y, 0);
      chk("R10", "corner", corner, 0);
      rst_n = 1'b1;

      // directed boundaries, T=16, four tiles
      run_pix("", 0, 30, 64, 64, 4, 4);
      run_pix("", 7, 7, 64, 64, 4, 4);
      run_pix("", 8, 8, 64, 64, 4, 4);
      run_pix("", 23, 40, 64, 64, 4, 4);
      run_pix("", 55, 55, 64, 64, 4, 4);
      run_pix("", 56, 63, 64, 64, 4, 4);
      run_pix("", 63, 0, 64, 64, 4, 4);
      // R11: out-of-range tile sizes are clamped
      run_pix("R11", 100, 100, 512, 512, 0, 7);
      run_pix("R11", 33, 200, 512, 512, 7, 1);
      // R12: tile count saturation and undersized image
      run_pix("R12", 4000, 3, 4095, 2, 2, 3);
      run_pix("R12", 255, 5, 4095, 20, 2, 5);

      // R9: idle cycle with different inputs keeps results
      run_pix("", 23, 40, 64, 64, 4, 4);
      drive(1'b0, 60, 2, 300, 900, 2, 6);
      chk("R8", "out_valid idle", out_valid, 0);
      check_all("R9", model(23, 64, 4), model(40, 64, 4));

      for (int i = 0; i < 3000; i++) begin
         int kw = $urandom_range(0, 7), kh = $urandom_range(0, 7);
         int tw = 1 << ((kw < KMIN) ? KMIN : (kw > KMAX ? KMAX : kw));
         int th = 1 << ((kh < KMIN) ? KMIN : (kh > KMAX ? KMAX : kh));
         int w = $urandom_range(tw, (tw * 70 > 4095) ? 4095 : tw * 70);
         int h = $urandom_range(th, (th * 70 > 4095) ? 4095 : th * 70);
         int x = $urandom_range(0, w - 1), y = $urandom_range(0, h - 1);
         run_pix("", x, y, w, h, kw, kh);
         if ($urandom_range(0, 7) == 0) begin
            drive(1'b0, $urandom_range(0, 4095), $urandom_range(0, 4095), w, h,
                  $urandom_range(0, 7), kh);
            chk("R8", "out_valid idle", out_valid, 0);
            check_all("R9", model(x, w, kw), model(y, h, kh));
         end
      end

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule